// File: doc/BRIEF.md
# ECP Host Handshake Engine

This block drives the host end of an Extended Capabilities Port link. On the forward path it takes tagged bytes from an upstream valid/ready source and moves each one to the peripheral with a four-phase strobe. The host acknowledge line marks each byte as data or command. On request it turns the link around. It stops driving the shared data bus, asks the peripheral for the reverse channel and waits for that grant. It then accepts bytes strobed in by the peripheral, whose acknowledge line now carries the data/command tag. Each received byte goes downstream as a one-cycle pulse, together with a decode of command bytes into channel address or run-length count.

All peripheral inputs pass through two-flop synchronisers before the control logic sees them. A cycle counter reports any handshake that waits too long on the peripheral. Dropping the mode-enable input ends any transfer in progress at once. A byte cut off in this way is never reported as sent.

Top module: `ecp_host_engine`

## Requirements
- R1: In reset, and after it until the first transfer, host_clk_o=1, host_ack_o=1, rev_req_n_o=1, active_o=0, bus_oe_o=1, sent_o=0, stall_o=0 and rev_valid_o=0.
- R2: Before host_clk_o falls for a forward byte, the byte is on bus_out_o with bus_oe_o=1 for at least one cycle, and host_ack_o carries the tag (1 = data, 0 = command). Both stay stable while host_clk_o is low; host_clk_o falls exactly two cycles after the upstream handshake (fwd_valid_i and fwd_ready_o both high).
- R3: host_clk_o returns high only after periph_ack_i has been high for its synchronised latency of three cycles. sent_o pulses for one cycle, in the same cycle that host_clk_o rises. fwd_ready_o stays low until periph_ack_i has been seen low again.
- R4: If active_i drops while host_clk_o is low, even after periph_ack_i has risen, the engine goes idle with host_clk_o high and sent_o never pulses for that byte.
- R5: When rev_req_i is raised while idle, bus_oe_o goes low at least one cycle before rev_req_n_o falls. No reverse byte is taken until ack_rev_n_i is low.
- R6: In reverse, host_ack_o goes high after periph_clk_i falls. When periph_clk_i rises, the byte on bus_in_i is captured and host_ack_o returns low. rev_valid_o pulses once with rev_cmd_o = NOT periph_ack_i (periph_ack_i high = data).
- R7: For a command byte, rev_is_addr_o equals bit 7 of the byte, and rev_field_o carries bits 6:0 (channel 0-127 when bit 7 is 1, run count when bit 7 is 0). For a data byte, rev_is_addr_o is 0.
- R8: When rev_req_i falls, rev_req_n_o returns high. fwd_ready_o stays low until ack_rev_n_i has been seen high again.
- R9: stall_o rises when a handshake wait (peripheral acknowledge, grant, release or strobe edge) has lasted STALL_CYCLES cycles. It clears once the wait ends.
- R10: active_o follows active_i one cycle later.
- R11: periph_req_o is the inverse of periph_req_n_i, delayed by the two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | Transfer mode enabled; low terminates |
| rev_req_i | input | 1 | Request reverse direction |
| fwd_valid_i | input | 1 | Upstream forward byte available |
| fwd_cmd_i | input | 1 | Forward byte is a command |
| fwd_byte_i | input | 8 | Forward byte |
| fwd_ready_o | output | 1 | Engine takes the forward byte this cycle |
| sent_o | output | 1 | Pulse: forward byte counted as transferred |
| rev_valid_o | output | 1 | Pulse: reverse byte received |
| rev_cmd_o | output | 1 | Received byte is a command |
| rev_byte_o | output | 8 | Received byte |
| rev_is_addr_o | output | 1 | Received command is a channel address |
| rev_field_o | output | 7 | Low seven bits of received byte |
| periph_req_o | output | 1 | Peripheral signals reverse data available |
| stall_o | output | 1 | Handshake wait exceeded limit |
| host_clk_o | output | 1 | Host strobe, active low |
| host_ack_o | output | 1 | Forward tag / reverse acknowledge |
| rev_req_n_o | output | 1 | Reverse request, active low |
| active_o | output | 1 | Mode-active line to peripheral |
| bus_out_o | output | 8 | Data bus value driven by host |
| bus_oe_o | output | 1 | Host drives data bus |
| bus_in_i | input | 8 | Data bus value seen at pins |
| periph_clk_i | input | 1 | Peripheral strobe, active low |
| periph_ack_i | input | 1 | Peripheral acknowledge / reverse tag |
| ack_rev_n_i | input | 1 | Reverse grant, active low |
| periph_req_n_i | input | 1 | Peripheral request, active low |

## Verification
A stuck or skipped state shows on the strobe lines within a few cycles. A forward state that leaves the strobe phase early raises host_clk_o before three cycles of acknowledge have passed. One that never leaves shows up as stall_o after STALL_CYCLES. A wrong tag register or a wrong capture edge corrupts rev_cmd_o or rev_byte_o on the very pulse concerned. A direction state that drives the bus too long is visible as bus_oe_o still high in the cycle before rev_req_n_o falls.

// File: rtl/ecp_host_pkg.sv
package ecp_host_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_F_SETUP, ST_F_STROBE, ST_F_RELEASE,
    ST_R_TURN, ST_R_GRANT, ST_R_IDLE, ST_R_HOLD, ST_R_EXIT
  } ecp_state_t;

  function automatic logic cmd_is_addr(input logic is_cmd, input logic [7:0] b);
    return is_cmd & b[7];
  endfunction

  function automatic logic [6:0] cmd_field(input logic [7:0] b);
    return b[6:0];
  endfunction
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int          W      = 1,
  parameter logic [W-1:0] RSTVAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RSTVAL;
      sync_q <= RSTVAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/ecp_stall_timer.sv
module ecp_stall_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting_i,
  input  logic restart_i,
  output logic stall_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (restart_i || !waiting_i) cnt_q <= '0;
    else if (cnt_q != CMAX)       cnt_q <= cnt_q + 1'b1;
  end
  assign stall_o = waiting_i && (cnt_q == CMAX);
endmodule

// File: rtl/ecp_host_engine.sv
module ecp_host_engine
  import ecp_host_pkg::*;
#(
  parameter int STALL_CYCLES = 64,
  parameter int DW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          rev_req_i,
  input  logic          fwd_valid_i,
  input  logic          fwd_cmd_i,
  input  logic [DW-1:0] fwd_byte_i,
  output logic          fwd_ready_o,
  output logic          sent_o,
  output logic          rev_valid_o,
  output logic          rev_cmd_o,
  output logic [DW-1:0] rev_byte_o,
  output logic          rev_is_addr_o,
  output logic [6:0]    rev_field_o,
  output logic          periph_req_o,
  output logic          stall_o,
  output logic          host_clk_o,
  output logic          host_ack_o,
  output logic          rev_req_n_o,
  output logic          active_o,
  output logic [DW-1:0] bus_out_o,
  output logic          bus_oe_o,
  input  logic [DW-1:0] bus_in_i,
  input  logic          periph_clk_i,
  input  logic          periph_ack_i,
  input  logic          ack_rev_n_i,
  input  logic          periph_req_n_i
);
  localparam int NCTL = 4;

  logic [NCTL-1:0] ctl_s;
  logic            pclk_s, pack_s, ackrev_n_s, preq_n_s;
  logic [DW-1:0]   data_s;

  ecp_sync #(.W(NCTL), .RSTVAL(4'b1101)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d_i({periph_clk_i, periph_req_n_i, periph_ack_i, ack_rev_n_i}),
    .q_o(ctl_s));
  ecp_sync #(.W(DW), .RSTVAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d_i(bus_in_i), .q_o(data_s));

  assign pclk_s     = ctl_s[3];
  assign preq_n_s   = ctl_s[2];
  assign pack_s     = ctl_s[1];
  assign ackrev_n_s = ctl_s[0];

  ecp_state_t    st_q, st_d;
  logic [DW-1:0] fbyte_q, rbyte_q;
  logic          fcmd_q, rtag_cmd_q, rvalid_q, rcmd_q, sent_q, active_q;
  logic          fwd_take, fwd_done, rev_edge_fall, rev_done, waiting;

  always_comb begin
    st_d = st_q;
    if (!active_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:      if (rev_req_i) st_d = ST_R_TURN;
                      else if (fwd_valid_i && !pack_s) st_d = ST_F_SETUP;
        ST_F_SETUP:   st_d = ST_F_STROBE;
        ST_F_STROBE:  if (pack_s) st_d = ST_F_RELEASE;
        ST_F_RELEASE: if (!pack_s) st_d = ST_IDLE;
        ST_R_TURN:    st_d = ST_R_GRANT;
        ST_R_GRANT:   if (!ackrev_n_s) st_d = ST_R_IDLE;
                      else if (!rev_req_i) st_d = ST_R_EXIT;
        ST_R_IDLE:    if (!pclk_s) st_d = ST_R_HOLD;
                      else if (!rev_req_i) st_d = ST_R_EXIT;
        ST_R_HOLD:    if (pclk_s) st_d = ST_R_IDLE;
        ST_R_EXIT:    if (ackrev_n_s) st_d = ST_IDLE;
        default:      st_d = ST_IDLE;
      endcase
    end
  end

  assign fwd_ready_o   = active_i && (st_q == ST_IDLE) && !rev_req_i && !pack_s;
  assign fwd_take      = fwd_ready_o && fwd_valid_i;
  assign fwd_done      = (st_q == ST_F_STROBE) && (st_d == ST_F_RELEASE);
  assign rev_edge_fall = (st_q == ST_R_IDLE) && (st_d == ST_R_HOLD);
  assign rev_done      = (st_q == ST_R_HOLD) && (st_d == ST_R_IDLE);
  assign waiting       = st_q inside {ST_F_STROBE, ST_F_RELEASE, ST_R_GRANT,
                                      ST_R_HOLD, ST_R_EXIT};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  fbyte_q <= '0; fcmd_q <= 1'b0;
      rtag_cmd_q <= 1'b0; rvalid_q <= 1'b0; rcmd_q <= 1'b0; rbyte_q <= '0;
      sent_q <= 1'b0; active_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      active_q <= active_i;
      sent_q   <= fwd_done;
      rvalid_q <= rev_done;
      if (fwd_take) begin
        fbyte_q <= fwd_byte_i;
        fcmd_q  <= fwd_cmd_i;
      end
      if (rev_edge_fall) rtag_cmd_q <= !pack_s;
      if (rev_done) begin
        rbyte_q <= data_s;
        rcmd_q  <= rtag_cmd_q;
      end
    end
  end

  ecp_stall_timer #(.LIMIT(STALL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .waiting_i(waiting),
    .restart_i(st_q != st_d), .stall_o(stall_o));

  always_comb begin
    unique case (st_q)
      ST_F_SETUP, ST_F_STROBE, ST_F_RELEASE: host_ack_o = !fcmd_q;
      ST_IDLE:                               host_ack_o = 1'b1;
      ST_R_HOLD:                             host_ack_o = 1'b1;
      default:                               host_ack_o = 1'b0;
    endcase
  end

  assign host_clk_o    = (st_q != ST_F_STROBE);
  assign rev_req_n_o   = !(st_q inside {ST_R_GRANT, ST_R_IDLE, ST_R_HOLD});
  assign bus_oe_o      = st_q inside {ST_IDLE, ST_F_SETUP, ST_F_STROBE, ST_F_RELEASE};
  assign bus_out_o     = fbyte_q;
  assign active_o      = active_q;
  assign sent_o        = sent_q;
  assign rev_valid_o   = rvalid_q;
  assign rev_cmd_o     = rcmd_q;
  assign rev_byte_o    = rbyte_q;
  assign rev_is_addr_o = cmd_is_addr(rcmd_q, rbyte_q);
  assign rev_field_o   = cmd_field(rbyte_q);
  assign periph_req_o  = !preq_n_s;
endmodule

// File: rtl/ecp_host_engine_chk.sv
module ecp_host_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_clk_o,
  input logic       host_ack_o,
  input logic [7:0] bus_out_o,
  input logic       bus_oe_o,
  input logic       rev_req_n_o,
  input logic       sent_o,
  input logic       rev_valid_o,
  input logic       rev_cmd_o,
  input logic       rev_is_addr_o,
  input logic [7:0] rev_byte_o,
  input logic       pack_s,
  input logic       ackrev_n_s
);
  AST_SENT_ON_CLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sent_o |-> $rose(host_clk_o)); // R3
  AST_SENT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    sent_o |-> $past(pack_s)); // R3
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_clk_o && $past(!host_clk_o)) |-> ($stable(bus_out_o) && $stable(host_ack_o))); // R2
  AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !host_clk_o |-> bus_oe_o); // R2
  AST_TRISTATE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rev_req_n_o) |-> $past(!bus_oe_o)); // R5
  AST_NO_DRIVE_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_req_n_o |-> !bus_oe_o); // R5
  AST_REV_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    rev_valid_o |-> !ackrev_n_s); // R5
  AST_ADDR_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    rev_is_addr_o |-> (rev_cmd_o && rev_byte_o[7])); // R7
endmodule

bind ecp_host_engine ecp_host_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_clk_o(host_clk_o), .host_ack_o(host_ack_o),
  .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o), .rev_req_n_o(rev_req_n_o),
  .sent_o(sent_o), .rev_valid_o(rev_valid_o), .rev_cmd_o(rev_cmd_o),
  .rev_is_addr_o(rev_is_addr_o), .rev_byte_o(rev_byte_o),
  .pack_s(pack_s), .ackrev_n_s(ackrev_n_s));

// File: tb/ecp_host_engine_tb.sv
module ecp_host_engine_tb;
  localparam int STALL = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic active_i = 0, rev_req_i = 0, fwd_valid_i = 0, fwd_cmd_i = 0;
  logic [7:0] fwd_byte_i = '0, bus_in_i = '0;
  logic periph_clk_i = 1, periph_ack_i = 0, ack_rev_n_i = 1, periph_req_n_i = 1;
  logic fwd_ready_o, sent_o, rev_valid_o, rev_cmd_o, rev_is_addr_o, periph_req_o;
  logic stall_o, host_clk_o, host_ack_o, rev_req_n_o, active_o, bus_oe_o;
  logic [7:0] rev_byte_o, bus_out_o;
  logic [6:0] rev_field_o;

  always #4 clk = ~clk;

  ecp_host_engine #(.STALL_CYCLES(STALL)) u_dut (
    .clk(clk), .rst_n(rst_n), .active_i(active_i), .rev_req_i(rev_req_i),
    .fwd_valid_i(fwd_valid_i), .fwd_cmd_i(fwd_cmd_i), .fwd_byte_i(fwd_byte_i),
    .fwd_ready_o(fwd_ready_o), .sent_o(sent_o), .rev_valid_o(rev_valid_o),
    .rev_cmd_o(rev_cmd_o), .rev_byte_o(rev_byte_o), .rev_is_addr_o(rev_is_addr_o),
    .rev_field_o(rev_field_o), .periph_req_o(periph_req_o), .stall_o(stall_o),
    .host_clk_o(host_clk_o), .host_ack_o(host_ack_o), .rev_req_n_o(rev_req_n_o),
    .active_o(active_o), .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o),
    .bus_in_i(bus_in_i), .periph_clk_i(periph_clk_i), .periph_ack_i(periph_ack_i),
    .ack_rev_n_i(ack_rev_n_i), .periph_req_n_i(periph_req_n_i));

  int n_vec = 0, n_bad = 0, sent_cnt = 0, rev_cnt = 0;
  logic [7:0] got_byte; logic got_cmd, got_addr; logic [6:0] got_field;
  bit done = 0;

  always @(negedge clk) begin
    if (sent_o) sent_cnt++;
    if (rev_valid_o) begin
      rev_cnt++; got_byte = rev_byte_o; got_cmd = rev_cmd_o;
      got_addr = rev_is_addr_o; got_field = rev_field_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // waits for host_clk_o to reach lvl, returns number of negedges taken
  task automatic wait_hclk(input logic lvl, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (host_clk_o !== lvl && n < 200);
  endtask

  task automatic wait_hack(input logic lvl, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (host_ack_o !== lvl && n < 200);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (fwd_ready_o !== 1'b1 && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic send_fwd(input logic [7:0] b, input logic is_cmd);
    int n, s0;
    wait_ready();
    fwd_valid_i = 1; fwd_byte_i = b; fwd_cmd_i = is_cmd;
    @(negedge clk); fwd_valid_i = 0;
    // R2: setup cycle, data and tag driven, strobe still high
    chk(host_clk_o && bus_oe_o && bus_out_o == b && host_ack_o == !is_cmd,
        "R2 setup", {host_clk_o, bus_out_o, host_ack_o}, {1'b1, b, !is_cmd});
    @(negedge clk);
    chk(!host_clk_o, "R2 strobe timing", host_clk_o, 0);
    chk(bus_out_o == b && host_ack_o == !is_cmd, "R2 hold", bus_out_o, b);
    s0 = sent_cnt;
    periph_ack_i = 1;
    wait_hclk(1'b1, n);
    chk(n == 3, "R3 release latency", n, 3);
    periph_ack_i = 0;
    @(negedge clk);
    chk(sent_cnt == s0 + 1, "R3 sent pulse", sent_cnt, s0 + 1);
    chk(!fwd_ready_o, "R3 wait ack low", fwd_ready_o, 0);
  endtask

  task automatic recv_rev(input logic [7:0] b, input logic is_data);
    int n, r0;
    r0 = rev_cnt;
    bus_in_i = b; periph_ack_i = is_data;
    @(negedge clk); periph_clk_i = 0;
    wait_hack(1'b1, n);
    chk(n == 3, "R6 ack rise", n, 3);
    periph_clk_i = 1;
    wait_hack(1'b0, n);
    chk(n == 3, "R6 ack fall", n, 3);
    @(negedge clk);
    chk(rev_cnt == r0 + 1 && got_byte == b, "R6 byte", got_byte, b);
    chk(got_cmd == !is_data, "R6 tag", got_cmd, !is_data);
    chk(got_addr == (!is_data && b[7]), "R7 addr decode", got_addr, !is_data && b[7]);
    chk(got_field == b[6:0], "R7 field", got_field, b[6:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_vec++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, s0, r0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(host_clk_o && host_ack_o && rev_req_n_o && !active_o && bus_oe_o &&
        !sent_o && !stall_o && !rev_valid_o, "R1 reset", 0, 1);
    rst_n = 1;
    @(negedge clk);
    chk(host_clk_o && rev_req_n_o && !active_o && !fwd_ready_o, "R1 after reset", 0, 1);
    active_i = 1;
    @(negedge clk);
    chk(active_o == 1, "R10 active follows", active_o, 1);

    // R11 request line
    periph_req_n_i = 0;
    @(negedge clk);
    chk(!periph_req_o, "R11 latency", periph_req_o, 0);
    @(negedge clk);
    chk(periph_req_o, "R11 asserted", periph_req_o, 1);
    periph_req_n_i = 1;

    // forward sweep over every byte, both tags (R2, R3)
    for (int i = 0; i < 512; i++) send_fwd(i[7:0], i[8]);

    // R9 stall during forward strobe, then recovery
    wait_ready();
    fwd_valid_i = 1; fwd_byte_i = 8'hA5; fwd_cmd_i = 0;
    @(negedge clk); fwd_valid_i = 0;
    @(negedge clk);
    n = 0;
    while (!stall_o && n < 100) begin @(negedge clk); n++; end
    chk(n == STALL, "R9 stall time", n, STALL);
    periph_ack_i = 1;
    wait_hclk(1'b1, n);
    chk(!stall_o, "R9 stall cleared", stall_o, 0);
    periph_ack_i = 0;
    repeat (4) @(negedge clk);

    // R4 abort after peripheral acknowledge
    wait_ready();
    s0 = sent_cnt;
    fwd_valid_i = 1; fwd_byte_i = 8'h3C; fwd_cmd_i = 1;
    @(negedge clk); fwd_valid_i = 0;
    @(negedge clk);
    periph_ack_i = 1; active_i = 0;
    @(negedge clk);
    chk(host_clk_o, "R4 strobe released", host_clk_o, 1);
    chk(!active_o, "R10 active dropped", active_o, 0);
    repeat (6) @(negedge clk);
    chk(sent_cnt == s0, "R4 no sent", sent_cnt, s0);
    periph_ack_i = 0; active_i = 1;
    repeat (4) @(negedge clk);

    // R5 turnaround
    rev_req_i = 1;
    @(negedge clk);
    chk(!bus_oe_o && rev_req_n_o, "R5 tristate first", bus_oe_o, 0);
    @(negedge clk);
    chk(!rev_req_n_o && !bus_oe_o, "R5 request low", rev_req_n_o, 0);
    r0 = rev_cnt;
    bus_in_i = 8'h11; periph_clk_i = 0;
    repeat (6) @(negedge clk);
    chk(host_ack_o == 0 && rev_cnt == r0, "R5 no capture before grant", host_ack_o, 0);
    periph_clk_i = 1;
    repeat (3) @(negedge clk);
    ack_rev_n_i = 0;
    repeat (4) @(negedge clk);

    // reverse sweep (R6, R7)
    for (int i = 0; i < 512; i++) recv_rev(i[7:0], i[8]);
    periph_ack_i = 0;

    // R8 return to forward
    rev_req_i = 0;
    @(negedge clk);
    chk(rev_req_n_o, "R8 request high", rev_req_n_o, 1);
    repeat (6) @(negedge clk);
    chk(!fwd_ready_o, "R8 wait for release", fwd_ready_o, 0);
    ack_rev_n_i = 1;
    n = 0;
    while (!fwd_ready_o && n < 50) begin @(negedge clk); n++; end
    chk(fwd_ready_o && bus_oe_o, "R8 forward again", fwd_ready_o, 1);
    send_fwd(8'h5A, 0);

    finish_run();
  end
endmodule